// File: doc/BRIEF.md
# Nibble-Bus ADC Word Reader

This block collects one 16-bit conversion result that reaches it over a 4-bit data bus. The converter can present either its upper or its lower 8 bits, chosen by a byte-select line. An external 2-to-1 multiplexer then narrows that byte to four wires, chosen by a nibble-select line. The reader steps both select lines through a fixed four-step sequence. After each select change it waits a parameterized settle time before it samples the bus. It shifts the four nibbles into a 16-bit word and reports that word with a one-cycle valid strobe.

Only the positive half of the converter's bipolar range is used, so the reported value has 15 significant bits. A result with its sign bit set is clipped to zero. A result with its sign bit clear is passed through with bit 15 cleared.

The host pulses `start_i` once the conversion has finished. It then waits for `valid_o`, or for `done_o` to return high. While a readout is running, further start pulses are ignored.

Top module: `nibble_word_reader`

## Requirements
- R1: After reset `done_o` is 1, `valid_o` is 0, `result_o` is 0, `byte_sel_o` is 0 and `nib_sel_o` is 1.
- R2: When `start_i` is high while `done_o` is high, a readout begins: `done_o` is low in the following cycle and stays low until the word is complete.
- R3: A readout drives the select pair {`byte_sel_o`,`nib_sel_o`} through 10, 11, 00, 01, in that order. `byte_sel_o`=1 selects the converter's upper byte. `nib_sel_o`=0 selects the A inputs, which carry bits [7:4] of the selected byte, and `nib_sel_o`=1 selects bits [3:0].
- R4: Each select setting is held for SETTLE_CYC+1 clock cycles, and the bus is sampled on the last edge of that hold. `valid_o` rises 4*(SETTLE_CYC+1) rising edges after the edge that accepted the start.
- R5: Nibbles are packed in sampling order: the first sample lands in bits [15:12] and the last sample lands in bits [3:0].
- R6: A reassembled word with bit 15 set is reported as 16'h0000.
- R7: A reassembled word with bit 15 clear is reported with bits [14:0] unchanged and bit 15 equal to 0.
- R8: `valid_o` is high for exactly one cycle per readout, in the cycle in which `done_o` returns high. `result_o` holds its value until the next valid.
- R9: A `start_i` pulse during a readout has no effect: the readout keeps its timing and produces exactly one valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin readout (accepted only when idle) |
| done_o | output | 1 | High when no readout is in progress |
| nib_i | input | 4 | Nibble bus from the external multiplexer |
| byte_sel_o | output | 1 | 1 = converter upper byte, 0 = lower byte |
| nib_sel_o | output | 1 | 0 = byte bits [7:4], 1 = byte bits [3:0] |
| result_o | output | 16 | Clipped unipolar result |
| valid_o | output | 1 | One-cycle strobe when result_o is updated |

## Verification
The bench models the converter's byte multiplexer and the external nibble multiplexer. The model deliberately corrupts the bus until the settle time has passed, so a reader that samples early returns a wrong word. Words with distinct nibbles such as 0x1234 and 0x7ABC separate wrong step orders and wrong packing. The values 0x0000, 0x7FFF, 0x8000 and 0xFFFF mark the clip boundary. Random words on both sides of the sign bit catch bit-level slips. A second start pulse during a readout shows whether the sequence restarts or produces an extra strobe.

// File: rtl/nwr_pkg.sv
// Shared types and helpers for the nibble-bus word reader.
package nwr_pkg;

    typedef enum logic {
        NWR_IDLE = 1'b0,
        NWR_RUN  = 1'b1
    } nwr_state_e;

    // Select pattern {byte_sel, nib_sel} for a given step index.
    function automatic logic [1:0] step_sel(input logic [1:0] step);
        return {~step[1], step[0]};
    endfunction

endpackage

// File: rtl/nwr_seq.sv
// Readout sequencer: walks four select steps, waits SETTLE_CYC cycles
// after each select change, then issues a sample strobe.
// Assumes start is only meaningful when idle; it is ignored otherwise.
module nwr_seq
    import nwr_pkg::*;
#(
    parameter int SETTLE_CYC = 3,
    parameter int STEPS      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic byte_sel_o,
    output logic nib_sel_o,
    output logic sample_o,
    output logic last_o,
    output logic done_o
);
    localparam int CNT_W  = $clog2(SETTLE_CYC + 2);
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
    localparam logic [CNT_W-1:0]  SETTLE    = CNT_W'(SETTLE_CYC);

    nwr_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;

    // Strobes derived from the current state.
    always_comb begin
        sample_o = (state_q == NWR_RUN) && (cnt_q == '0);
        last_o   = sample_o && (step_q == LAST_STEP);
        done_o   = (state_q == NWR_IDLE);
    end

    // State, step index, settle counter and registered select lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q                 <= NWR_IDLE;
            step_q                  <= '0;
            cnt_q                   <= '0;
            {byte_sel_o, nib_sel_o} <= step_sel(2'd3);
        end else begin
            case (state_q)
                NWR_IDLE: begin
                    if (start_i) begin
                        state_q                 <= NWR_RUN;
                        step_q                  <= '0;
                        cnt_q                   <= SETTLE;
                        {byte_sel_o, nib_sel_o} <= step_sel(2'd0);
                    end
                end
                default: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (step_q == LAST_STEP) begin
                        state_q <= NWR_IDLE;
                    end else begin
                        step_q                  <= step_q + 1'b1;
                        cnt_q                   <= SETTLE;
                        {byte_sel_o, nib_sel_o} <= step_sel(2'(step_q + 1'b1));
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nwr_assemble.sv
// Word assembler: shifts sampled nibbles in MSB first, then clips the
// finished word to the unipolar range and pulses valid.
// Assumes last_i is only high together with sample_i.
module nwr_assemble #(
    parameter int NIB_W  = 4,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [WORD_W-1:0] result_o,
    output logic              valid_o
);
    localparam int KEEP_W = WORD_W - NIB_W;

    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] next_word;

    // Word as it stands once the current nibble is shifted in.
    always_comb next_word = {shift_q[KEEP_W-1:0], nib_i};

    // Shift register, clipped result register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (sample_i) begin
                shift_q <= next_word;
            end
            if (last_i) begin
                valid_o  <= 1'b1;
                result_o <= next_word[WORD_W-1] ? '0
                                                : {1'b0, next_word[WORD_W-2:0]};
            end
        end
    end

endmodule

// File: rtl/nibble_word_reader.sv
// Top: reads a 16-bit converter word over a 4-bit bus through two
// select lines, and reports the unipolar-clipped result.
// Assumes the bus is valid SETTLE_CYC cycles after a select change.
module nibble_word_reader #(
    parameter int SETTLE_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        done_o,
    input  logic [3:0]  nib_i,
    output logic        byte_sel_o,
    output logic        nib_sel_o,
    output logic [15:0] result_o,
    output logic        valid_o
);
    localparam int NIB_W  = 4;
    localparam int WORD_W = 16;
    localparam int STEPS  = WORD_W / NIB_W;

    logic sample;
    logic last;

    nwr_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .STEPS      (STEPS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_sel_o (byte_sel_o),
        .nib_sel_o  (nib_sel_o),
        .sample_o   (sample),
        .last_o     (last),
        .done_o     (done_o)
    );

    nwr_assemble #(
        .NIB_W  (NIB_W),
        .WORD_W (WORD_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .last_i   (last),
        .nib_i    (nib_i),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/nwr_checker.sv
// Property checker for nibble_word_reader, attached by bind below.
module nwr_checker #(
    parameter int SETTLE_CYC = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        done_o,
    input logic        byte_sel_o,
    input logic        nib_sel_o,
    input logic [15:0] result_o,
    input logic        valid_o
);
    logic [1:0] sel_q;
    int         hold_q;
    logic       busy_q;

    // Track how long the select pair has been stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 2'b01;
            hold_q <= 0;
            busy_q <= 1'b0;
        end else begin
            sel_q  <= {byte_sel_o, nib_sel_o};
            busy_q <= !done_o;
            if ({byte_sel_o, nib_sel_o} != sel_q) hold_q <= 0;
            else if (hold_q < SETTLE_CYC + 8)     hold_q <= hold_q + 1;
            // R4: a select step is never cut short during a readout.
            if (busy_q && ({byte_sel_o, nib_sel_o} != sel_q))
                a_r4_settle_held: assert (hold_q >= SETTLE_CYC);
        end
    end

    a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);

    a_r3_select_order: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({byte_sel_o, nib_sel_o}) |->
            ({byte_sel_o, nib_sel_o} == 2'($past({byte_sel_o, nib_sel_o}) + 2'd1)));

    a_r7_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !result_o[15]);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r8_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (done_o && $rose(done_o)));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

endmodule

bind nibble_word_reader nwr_checker #(.SETTLE_CYC(SETTLE_CYC)) u_nwr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .byte_sel_o (byte_sel_o),
    .nib_sel_o  (nib_sel_o),
    .result_o   (result_o),
    .valid_o    (valid_o)
);

// File: tb/nibble_word_reader_bench.sv
module nibble_word_reader_bench;
    localparam int S       = 3;
    localparam int LAT     = 4 * (S + 1) + 1; // negedges from start drive to valid

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        done_o;
    logic [3:0]  nib_i;
    logic        byte_sel_o;
    logic        nib_sel_o;
    logic [15:0] result_o;
    logic        valid_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] adc_word = '0;
    logic [1:0]  prev_sel = 2'b01;
    int          age = 0;
    logic [7:0]  byte_bus;
    logic [3:0]  clean_nib;

    logic [1:0] seen_sel [0:7];
    int         seen_n = 0;
    logic [1:0] last_seen = 2'b01;

    always #5 clk = ~clk;

    nibble_word_reader #(.SETTLE_CYC(S)) u_nibble_word_reader (
        .clk, .rst_n, .start_i, .done_o, .nib_i,
        .byte_sel_o, .nib_sel_o, .result_o, .valid_o
    );

    // Converter byte mux and external nibble mux, with corrupt data until settled.
    always_comb begin
        byte_bus  = byte_sel_o ? adc_word[15:8] : adc_word[7:0];
        clean_nib = nib_sel_o ? byte_bus[3:0] : byte_bus[7:4];
        nib_i     = (age < S - 1) ? ~clean_nib : clean_nib;
    end

    always @(posedge clk) begin
        prev_sel <= {byte_sel_o, nib_sel_o};
        if ({byte_sel_o, nib_sel_o} != prev_sel) age <= 0;
        else if (age < 100) age <= age + 1;
    end

    // Record select pattern changes.
    always @(negedge clk) begin
        if ({byte_sel_o, nib_sel_o} != last_seen) begin
            if (seen_n < 8) seen_sel[seen_n] <= {byte_sel_o, nib_sel_o};
            seen_n    <= seen_n + 1;
            last_seen <= {byte_sel_o, nib_sel_o};
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [15:0] w);
        return w[15] ? 16'h0 : {1'b0, w[14:0]};
    endfunction

    // R1: reset values.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", done_o, 1);
        check("R1 valid", valid_o, 0);
        check("R1 result", result_o, 0);
        check("R1 byte_sel", byte_sel_o, 0);
        check("R1 nib_sel", nib_sel_o, 1);
    endtask

    // R2..R9: one readout of word w; optional second start at cycle extra (0 = none).
    task automatic t_read(input logic [15:0] w, input int extra, input bit chk_order);
        int n = 0;
        int valids = 0;
        int first = 0;
        adc_word = w;
        seen_n   = 0;
        @(negedge clk);
        start_i = 1'b1;
        while (n < 200) begin
            @(negedge clk);
            n++;
            start_i = (extra != 0 && n == extra);
            if (n == 1) check("R2 done low", done_o, 0);
            if (valid_o) begin
                valids++;
                if (first == 0) begin
                    first = n;
                    check("R5 R6 R7 word", result_o, expect_word(w));
                    check("R8 done with valid", done_o, 1);
                end
            end
            if (first != 0 && n >= first + 2 * LAT) break;
            if (first == 0 && n > 2 && n < LAT && done_o) begin
                check("R2 done stays low", done_o, 0);
            end
        end
        start_i = 1'b0;
        check("R4 latency", first, LAT);
        check("R8 R9 single valid", valids, 1);
        check("R8 result held", result_o, expect_word(w));
        if (chk_order) begin
            check("R3 step count", seen_n, 4);
            check("R3 step0", seen_sel[0], 2'b10);
            check("R3 step1", seen_sel[1], 2'b11);
            check("R3 step2", seen_sel[2], 2'b00);
            check("R3 step3", seen_sel[3], 2'b01);
        end
    endtask

    initial begin
        t_reset();
        t_read(16'h1234, 0, 1);   // R5 packing order
        t_read(16'h7ABC, 0, 1);   // R7 positive passthrough
        t_read(16'h0000, 0, 0);
        t_read(16'h7FFF, 0, 0);   // R7 top of range
        t_read(16'h8000, 0, 0);   // R6 clip
        t_read(16'hFFFF, 0, 0);   // R6 clip
        t_read(16'h4321, 6, 1);   // R9 start while busy
        t_read(16'h9876, 12, 0);  // R9 with clipped word
        for (int i = 0; i < 16; i++) begin
            t_read(16'($urandom), 0, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule